// File: doc/BRIEF.md
# One-hot control sequencer with parity upset detection

This block is a five-state request/acknowledge sequencer. It is built for parts exposed to radiation, where a particle strike can flip a storage bit without leaving permanent damage. Each state has its own flip-flop, so a legal state vector has exactly one bit set. A parity monitor examines the vector on every cycle. A legal vector always holds an odd number of ones. If the count is even, the vector is corrupt: the outputs are forced to their safe low values, the operation in progress is dropped, and the idle state is reloaded on the next clock edge.

A request is raised when a caller pulses `start`. The sequencer holds `req` until the responder raises `ack`. It then waits for `ack` to fall, passes through a completion state, and waits for `start` to be released before it returns to idle. A five-bit injection input flips chosen state bits at a clock edge, so a bench can model upsets. The raw state vector is brought out for observation.

Parity cannot see an upset that leaves an odd count of ones. For that case, each output is decoded from a full state pattern, so a vector with several bits set still cannot drive `req` or `busy`.

Top module: `ohf_ctrl`

## Requirements
- R1: While `rst_n` is low, `state` is 5'b00001 (idle) and `req`, `busy` and `parity_error` are 0. Reset takes effect at once when `rst_n` falls. After `rst_n` rises, it is released on the second rising clock edge, so the machine first updates on the third edge.
- R2: The state bits are idle=bit0, request=bit1, wait=bit2, done=bit3 and hold=bit4. The transitions are:
  - idle goes to request when `start` is 1, and stays in idle otherwise;
  - request goes to wait when `ack` is 1, and stays otherwise;
  - wait goes to done when `ack` is 0, and stays otherwise;
  - done always goes to hold;
  - hold goes to idle when `start` is 0, and stays otherwise.
- R3: `req` is 1 exactly while the state is request. `busy` is 1 exactly while the state is request, wait, done or hold. Both are 0 in idle.
- R4: A state vector with an even number of ones, the all-zero vector included, is a mismatch. On the next rising edge the machine loads idle and the interrupted operation is not resumed.
- R5: While the state vector is a mismatch, `req` and `busy` are 0.
- R6: `parity_error` is 1 for exactly the one cycle that follows a cycle in which the vector was a mismatch, that is, together with the reloaded idle state. It is 0 otherwise.
- R7: Bit i of `fault_flip` at a rising edge inverts bit i of the vector loaded at that edge.
- R8: A single-bit flip injected from any of the five states is flagged and recovered to idle.
- R9: A vector with more than one bit set never raises `req` or `busy`, even when parity misses it.
- R10: A vector with three bits set keeps odd parity and is not flagged: `parity_error` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| start | input | 1 | Begin a request; held high until the sequence reaches hold |
| ack | input | 1 | Responder acknowledge |
| fault_flip | input | 5 | Per-bit inversion applied to the state loaded at the clock edge |
| req | output | 1 | Request to the responder |
| busy | output | 1 | Sequence in progress |
| parity_error | output | 1 | One-cycle pulse reporting a detected upset |
| state | output | 5 | Raw one-hot state vector |

## Verification
The recovery and idle-exit properties assume that `fault_flip` is zero at the edge that follows a detected mismatch or an idle exit. The error-pulse property assumes that injections come as isolated one-cycle pulses, not on back-to-back edges. The stimulus keeps to these assumptions. It raises `fault_flip` for a single edge, clears it at the next falling edge, and lets at least two clean edges pass before the next injection. It changes `start` and `ack` only at falling edges. After a three-bit injection, the vector is not predicted any further; the bench returns the block to a known state with a reset.

// File: rtl/ohf_pkg.sv
package ohf_pkg;
  localparam int unsigned NUM_ST = 5;

  localparam int unsigned IX_IDLE = 0;
  localparam int unsigned IX_REQ  = 1;
  localparam int unsigned IX_WAIT = 2;
  localparam int unsigned IX_DONE = 3;
  localparam int unsigned IX_HOLD = 4;

  typedef logic [NUM_ST-1:0] st_vec_t;

  localparam st_vec_t ST_IDLE = st_vec_t'(1) << IX_IDLE;
  localparam st_vec_t ST_REQ  = st_vec_t'(1) << IX_REQ;
  localparam st_vec_t ST_WAIT = st_vec_t'(1) << IX_WAIT;
  localparam st_vec_t ST_DONE = st_vec_t'(1) << IX_DONE;
  localparam st_vec_t ST_HOLD = st_vec_t'(1) << IX_HOLD;
endpackage

// File: rtl/ohf_rst_sync.sv
module ohf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  // Reset asserts at once and releases through the flop chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ohf_parity_mon.sv
module ohf_parity_mon
  import ohf_pkg::*;
(
  input  st_vec_t st_i,
  output logic    mismatch_o
);
  // A legal one-hot word always holds an odd number of ones.
  always_comb begin
    mismatch_o = ~(^st_i);
  end
endmodule

// File: rtl/ohf_next_state.sv
module ohf_next_state
  import ohf_pkg::*;
(
  input  st_vec_t st_i,
  input  logic    start_i,
  input  logic    ack_i,
  output st_vec_t nxt_o
);
  // One equation per state flop, each built from the flops that can enter it.
  always_comb begin
    nxt_o          = '0;
    nxt_o[IX_IDLE] = (st_i[IX_IDLE] & ~start_i) | (st_i[IX_HOLD] & ~start_i);
    nxt_o[IX_REQ]  = (st_i[IX_IDLE] &  start_i) | (st_i[IX_REQ]  & ~ack_i);
    nxt_o[IX_WAIT] = (st_i[IX_REQ]  &  ack_i)   | (st_i[IX_WAIT] &  ack_i);
    nxt_o[IX_DONE] =  st_i[IX_WAIT] & ~ack_i;
    nxt_o[IX_HOLD] =  st_i[IX_DONE] | (st_i[IX_HOLD] & start_i);
  end
endmodule

// File: rtl/ohf_out_dec.sv
module ohf_out_dec
  import ohf_pkg::*;
(
  input  logic    clk,
  input  logic    srst_n,
  input  st_vec_t st_i,
  input  logic    mismatch_i,
  output logic    req_o,
  output logic    busy_o
);
  logic [NUM_ST-1:0] hit;

  // Full-pattern match per state: a multi-hot word matches no state.
  for (genvar gi = 0; gi < NUM_ST; gi++) begin : g_hit
    localparam st_vec_t CODE = st_vec_t'(1) << gi;
    assign hit[gi] = (st_i == CODE);
  end

  always_comb begin
    req_o  = hit[IX_REQ] & ~mismatch_i;
    busy_o = (|hit[NUM_ST-1:1]) & ~mismatch_i;
  end

  AST_SAFE_OUT: assert property (@(posedge clk) disable iff (!srst_n)
    mismatch_i |-> (!req_o && !busy_o)); // R5
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    req_o |-> ($countones(st_i) == 1)); // R9
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    busy_o |-> ($countones(st_i) == 1)); // R9
endmodule

// File: rtl/ohf_ctrl.sv
module ohf_ctrl
  import ohf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ack,
  input  logic [NUM_ST-1:0] fault_flip,
  output logic              req,
  output logic              busy,
  output logic              parity_error,
  output logic [NUM_ST-1:0] state
);
  logic    srst_n;
  st_vec_t st_q;
  st_vec_t st_d;
  st_vec_t st_nxt;
  logic    mismatch;
  logic    perr_q;

  ohf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ohf_parity_mon u_parity (
    .st_i       (st_q),
    .mismatch_o (mismatch)
  );

  ohf_next_state u_next (
    .st_i    (st_q),
    .start_i (start),
    .ack_i   (ack),
    .nxt_o   (st_nxt)
  );

  ohf_out_dec u_dec (
    .clk        (clk),
    .srst_n     (srst_n),
    .st_i       (st_q),
    .mismatch_i (mismatch),
    .req_o      (req),
    .busy_o     (busy)
  );

  // Recovery overrides the transition logic; the injected upset lands on top.
  always_comb begin
    st_d = (mismatch ? ST_IDLE : st_nxt) ^ fault_flip;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      perr_q <= mismatch;
    end
  end

  assign state        = st_q;
  assign parity_error = perr_q;

  AST_RECOVER_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (mismatch && fault_flip == '0) |=> (state == ST_IDLE)); // R4
  AST_PERR_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    mismatch |=> parity_error); // R6
  AST_PERR_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !mismatch |=> !parity_error); // R6
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IDLE && start && fault_flip == '0) |=> (state == ST_REQ)); // R2
endmodule

// File: tb/test_ohf_ctrl.sv
module test_ohf_ctrl;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic       ack;
  logic [4:0] fault_flip;
  logic       req;
  logic       busy;
  logic       parity_error;
  logic [4:0] state;

  int total = 0;
  int bad   = 0;

  localparam logic [4:0] S_IDLE = 5'b00001;
  localparam logic [4:0] S_REQ  = 5'b00010;
  localparam logic [4:0] S_WAIT = 5'b00100;
  localparam logic [4:0] S_DONE = 5'b01000;
  localparam logic [4:0] S_HOLD = 5'b10000;

  ohf_ctrl i_ohf_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ack          (ack),
    .fault_flip   (fault_flip),
    .req          (req),
    .busy         (busy),
    .parity_error (parity_error),
    .state        (state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [4:0] mq;
  logic       mperr;
  int         rcnt;
  bit         unk;
  logic [4:0] nx;
  bit         even;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq <= S_IDLE; mperr <= 1'b0; rcnt <= 0; unk <= 1'b0;
    end else if (rcnt < 2) begin
      rcnt <= rcnt + 1; mq <= S_IDLE; mperr <= 1'b0;
    end else begin
      even = ($countones(mq) % 2) == 0;
      if (even) nx = S_IDLE;
      else begin
        case (mq)
          S_IDLE:  nx = start ? S_REQ  : S_IDLE;
          S_REQ:   nx = ack   ? S_WAIT : S_REQ;
          S_WAIT:  nx = ack   ? S_WAIT : S_DONE;
          S_DONE:  nx = S_HOLD;
          S_HOLD:  nx = start ? S_HOLD : S_IDLE;
          default: begin nx = mq; unk <= 1'b1; end
        endcase
      end
      mq    <= nx ^ fault_flip;
      mperr <= even;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rcnt >= 2 && !unk && ($countones(mq) % 2 == 0 || $countones(mq) == 1)) begin
      check(state == mq, "R2 R7 state", state, mq);
      check(req == (mq == S_REQ && $countones(mq) == 1), "R3 req", req, mq == S_REQ);
      check(busy == (mq inside {S_REQ, S_WAIT, S_DONE, S_HOLD}), "R3 busy", busy,
            mq inside {S_REQ, S_WAIT, S_DONE, S_HOLD});
      check(parity_error == mperr, "R6 parity_error", parity_error, mperr);
    end
  end

  task automatic nclk();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; ack = 1'b0; fault_flip = '0;
    repeat (3) nclk();
    check(state == S_IDLE && !req && !busy && !parity_error, "R1 in reset", state, S_IDLE);
    rst_n = 1'b1;
    repeat (3) nclk();
    check(state == S_IDLE && !req && !busy, "R1 after release", state, S_IDLE);
  endtask

  task automatic goto_state(input int s);
    start = 1'b0; ack = 1'b0;
    nclk();
    if (s >= 1) begin start = 1'b1; nclk(); end
    if (s >= 2) begin ack = 1'b1; nclk(); end
    if (s >= 3) begin ack = 1'b0; nclk(); end
    if (s >= 4) nclk();
  endtask

  initial begin : main
    do_reset();

    // Handshake, ack arriving late
    start = 1'b1; nclk();
    check(state == S_REQ && req && busy, "R2 R3 enter request", state, S_REQ);
    nclk(); nclk();
    check(state == S_REQ && req, "R2 request waits for ack", state, S_REQ);
    ack = 1'b1; nclk();
    check(state == S_WAIT && !req && busy, "R2 R3 wait", state, S_WAIT);
    nclk();
    check(state == S_WAIT, "R2 wait holds while ack", state, S_WAIT);
    ack = 1'b0; nclk();
    check(state == S_DONE && busy, "R2 done", state, S_DONE);
    nclk();
    check(state == S_HOLD && busy, "R2 hold", state, S_HOLD);
    nclk();
    check(state == S_HOLD, "R2 hold while start", state, S_HOLD);
    start = 1'b0; nclk();
    check(state == S_IDLE && !busy, "R2 R3 back to idle", state, S_IDLE);

    // Handshake, ack already high
    ack = 1'b1; start = 1'b1; nclk();
    check(state == S_REQ, "R2 request with early ack", state, S_REQ);
    nclk();
    check(state == S_WAIT, "R2 early ack moves on", state, S_WAIT);
    ack = 1'b0; start = 1'b0; nclk(); nclk(); nclk();
    check(state == S_IDLE, "R2 short sequence ends idle", state, S_IDLE);

    // Single-bit injection from every state
    for (int s = 0; s < 5; s++) begin
      for (int b = 0; b < 5; b++) begin
        goto_state(s);
        fault_flip = 5'(1) << b;
        nclk();
        fault_flip = '0;
        check($countones(state) % 2 == 0, "R7 R8 flip makes even vector", state, 0);
        check(!req && !busy, "R5 safe outputs", {req, busy}, 0);
        if (state == 5'b0) check(1'b1, "R4 all-zero vector seen", state, 0);
        start = 1'b0; ack = 1'b0;
        nclk();
        check(state == S_IDLE, "R4 R8 recovered to idle", state, S_IDLE);
        check(parity_error, "R6 R8 error pulse", parity_error, 1);
        nclk();
        check(!parity_error, "R6 pulse lasts one cycle", parity_error, 0);
      end
    end

    // Three bits set: parity blind, outputs still held low
    goto_state(0);
    fault_flip = 5'b00110;
    nclk();
    fault_flip = '0;
    check(state == 5'b00111, "R7 three-bit vector", state, 5'b00111);
    check(!parity_error, "R10 not flagged", parity_error, 0);
    check(!req && !busy, "R9 multi-hot drives nothing", {req, busy}, 0);
    nclk();
    check(state == 5'b01011, "R10 still three bits", state, 5'b01011);
    check(!parity_error, "R10 still not flagged", parity_error, 0);
    check(!req && !busy, "R9 outputs still low", {req, busy}, 0);

    do_reset();
    start = 1'b1; nclk();
    check(state == S_REQ && req, "R1 R2 usable after reset", state, S_REQ);
    start = 1'b0; ack = 1'b1; nclk(); ack = 1'b0; nclk(); nclk(); nclk();
    check(state == S_IDLE, "R2 final idle", state, S_IDLE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule